// File: doc/BRIEF.md
# Concurrent Serial Configuration Streamer

This block takes one byte stream from a memory read port and feeds up to eight serial configuration chains in parallel. Every chain has its own data line. All chains share one configuration clock, one active-low program pulse, and the init and done handshakes. The memory holds the chain streams interleaved bit by bit. The block takes each byte apart into groups of one, two, four or eight bits, and each group is placed on the data lines for a single clock period.

A run starts with a one-cycle `start`. The block latches the chain count and the clock divider, then drives the program pulse for a fixed number of cycles. It waits for init to go high and then streams the data. Once the last bit has gone out, it keeps the clock running until done rises, which ends the run as finished. If done does not rise within a fixed number of clock pulses, the run ends as a timeout.

The shared clock is paced from the system clock. The per-chain rate ceiling and the total memory read ceiling both set a floor on the clock's half period, and the floor depends on the chain count. A slower setting in the divider input is honoured. When the memory cannot deliver the next group in time, the clock simply waits, so no bit is ever skipped.

Top module: `cfg_streamer`

## Requirements
- R1: After `start` is accepted, `cfg_prog_n` is low for exactly PROG_CYCLES system clock cycles and then returns high.
- R2: `cfg_cclk` never rises while `cfg_init` is low after the program pulse. Streaming begins only once `cfg_init` has been seen high.
- R3: The chain count N is selected by `chain_mode`: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. Stream bits are consumed LSB first within each byte. Stream bit r*N+k appears on `cfg_data[k]` at the r-th rising edge of `cfg_cclk`. Lines k ≥ N stay 0, and `cfg_data` does not change while `cfg_cclk` is high.
- R4: Whatever gaps occur in `mem_valid`, a stream of B bytes produces exactly 8*B/N rising edges before the drain phase, in stream order.
- R5: Each high phase of `cfg_cclk` lasts at least H system cycles, and so does each low phase that follows a falling edge. H = max(`div_half`, Hmin(N)). With the default 250 MHz system clock, 66 Mb/s per-chain limit and 152 Mb/s total limit, Hmin is 2, 2, 4 and 7 for N = 1, 2, 4 and 8.
- R6: When `mem_valid` is held high, every high phase and every low phase after a falling edge lasts exactly H cycles.
- R7: If `cfg_done` rises during the drain phase, the block stops clocking with no further rising edge. `finished` then goes high, and `busy` and `cfg_cclk` go low.
- R8: If `cfg_done` stays low for TIMEOUT_CLKS drain-phase rising edges, `timeout_err` goes high, `finished` stays low and clocking stops.
- R9: While in reset and just after it, `cfg_prog_n`=1, `cfg_cclk`=0, `cfg_data`=0, `mem_ready`=0, `busy`=0, `finished`=0 and `timeout_err`=0.
- R10: `mem_ready` is high only while a run is streaming, never while idle or during the program pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| chain_mode | input | 2 | Chain count select (1, 2, 4, 8) |
| div_half | input | DIV_W | Requested half period of the configuration clock, in system cycles |
| mem_data | input | BYTE_W | Interleaved stream byte |
| mem_valid | input | 1 | Stream byte is offered |
| mem_last | input | 1 | Offered byte is the final one |
| mem_ready | output | 1 | Block accepts the offered byte |
| cfg_prog_n | output | 1 | Shared active-low program pulse |
| cfg_init | input | 1 | Shared init handshake, high when targets are ready |
| cfg_cclk | output | 1 | Shared configuration clock |
| cfg_data | output | MAX_LANES | One data line per chain |
| cfg_done | input | 1 | Shared done handshake |
| busy | output | 1 | Run in progress |
| finished | output | 1 | Last run ended with done seen |
| timeout_err | output | 1 | Last run ended without done |

## Verification
Several properties are checked on every cycle: the program pulse width, the absence of a clock rise before init, data holding still across each high phase, unused lines held at zero, the high-phase floor for the latched chain count, the ready signal being confined to streaming, and each outcome flag being caused by the right done level. Only the bench scenarios can show the bit-to-line mapping over whole streams, the exact edge counts under memory gaps, the exact phase widths when the divider dominates, and the full timeout count. The bench sweeps every chain count against several divider settings, with and without memory gaps.

// File: rtl/cfg_streamer_pkg.sv
// Shared types and the clock-rate floor computation for the streamer.
// Assumes integer MHz / Mb/s figures and a system clock at least twice
// the per-chain ceiling.
package cfg_streamer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAIT_INIT,
        ST_STREAM,
        ST_DRAIN,
        ST_FINISH,
        ST_FAULT
    } seq_state_t;

    // Smallest legal half period (system cycles) for a given lane count.
    function automatic int unsigned min_half(int unsigned sys_mhz,
                                             int unsigned chain_mbps,
                                             int unsigned total_mbps,
                                             int unsigned lanes);
        int unsigned per;
        int unsigned agg;
        int unsigned per_max;
        int unsigned half;
        per     = (sys_mhz + chain_mbps - 1) / chain_mbps;
        agg     = (sys_mhz * lanes + total_mbps - 1) / total_mbps;
        per_max = (per > agg) ? per : agg;
        half    = (per_max + 1) / 2;
        return (half < 2) ? 2 : half;
    endfunction

endpackage

// File: rtl/cfg_clk_pacer.sv
// Shared configuration clock generator.
// Toggles cfg_cclk after an effective half period of the larger of the
// requested divider and the rate floor for the chosen lane count.
// A rising edge is issued only when run and gate are both high; a high
// phase always completes with a falling edge. Assumes mode and div are
// stable for the whole run.
module cfg_clk_pacer
    import cfg_streamer_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int SYS_MHZ    = 250,
    parameter int CHAIN_MBPS = 66,
    parameter int TOTAL_MBPS = 152
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [DIV_W-1:0] div_half,
    input  logic             run,
    input  logic             gate,
    output logic             cclk,
    output logic             rise_now,
    output logic             fall_now
);

    localparam logic [DIV_W-1:0] HMIN [4] = '{
        DIV_W'(min_half(SYS_MHZ, CHAIN_MBPS, TOTAL_MBPS, 1)),
        DIV_W'(min_half(SYS_MHZ, CHAIN_MBPS, TOTAL_MBPS, 2)),
        DIV_W'(min_half(SYS_MHZ, CHAIN_MBPS, TOTAL_MBPS, 4)),
        DIV_W'(min_half(SYS_MHZ, CHAIN_MBPS, TOTAL_MBPS, 8))
    };

    logic [DIV_W-1:0] eff;
    logic [DIV_W-1:0] cnt_q;
    logic             at_end;

    // Pick the effective half period: requested value, but never below the floor.
    always_comb begin
        eff = (div_half > HMIN[mode]) ? div_half : HMIN[mode];
    end

    assign at_end   = (cnt_q >= (eff - 1'b1));
    assign rise_now = run && !cclk && gate && at_end;
    assign fall_now = cclk && at_end;

    // Phase counter and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cclk  <= 1'b0;
            cnt_q <= '0;
        end else if (rise_now || fall_now) begin
            cclk  <= ~cclk;
            cnt_q <= '0;
        end else if (!at_end) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_lane_unpack.sv
// Byte fetch and lane de-interleaver.
// Holds one stream byte, hands out groups of N bits (LSB first) onto the
// per-chain data lines while the shared clock is low, and marks a group
// pending until the next falling edge. Assumes MAX_LANES <= BYTE_W and
// that BYTE_W is a multiple of 8 / N for every lane count.
module cfg_lane_unpack #(
    parameter int MAX_LANES = 8,
    parameter int BYTE_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 enable,
    input  logic [1:0]           mode,
    input  logic [BYTE_W-1:0]    mem_data,
    input  logic                 mem_valid,
    input  logic                 mem_last,
    output logic                 mem_ready,
    input  logic                 cclk,
    input  logic                 fall_now,
    output logic                 pend,
    output logic                 drained,
    output logic [MAX_LANES-1:0] cfg_data
);

    localparam int LEFT_W = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0]    sh_q;
    logic [LEFT_W-1:0]    left_q;
    logic [LEFT_W-1:0]    step;
    logic                 last_q;
    logic                 load;
    logic [MAX_LANES-1:0] group;

    assign step      = LEFT_W'(1) << mode;
    assign mem_ready = enable && (left_q == '0) && !last_q;
    assign load      = enable && !cclk && !pend && (left_q != '0);
    assign drained   = last_q && (left_q == '0) && !pend;

    // One gated bit per lane: lanes beyond the active count stay zero.
    for (genvar k = 0; k < MAX_LANES; k++) begin : g_lane
        assign group[k] = (LEFT_W'(k) < step) ? sh_q[k] : 1'b0;
    end

    // Byte buffer, group hand-out and pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sh_q     <= '0;
            left_q   <= '0;
            last_q   <= 1'b0;
            pend     <= 1'b0;
            cfg_data <= '0;
        end else begin
            if (mem_ready && mem_valid) begin
                sh_q   <= mem_data;
                left_q <= LEFT_W'(BYTE_W);
                last_q <= mem_last;
            end
            if (load) begin
                cfg_data <= group;
                sh_q     <= sh_q >> step;
                left_q   <= left_q - step;
                pend     <= 1'b1;
            end
            if (fall_now) begin
                pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cfg_seq_ctrl.sv
// Run sequencer: program pulse, init wait, streaming, drain with done
// watch and timeout. Latches lane mode and divider when a run starts.
// Assumes the init and done inputs are already synchronous to clk.
module cfg_seq_ctrl
    import cfg_streamer_pkg::*;
#(
    parameter int DIV_W        = 8,
    parameter int PROG_CYCLES  = 8,
    parameter int TIMEOUT_CLKS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       chain_mode,
    input  logic [DIV_W-1:0] div_half,
    input  logic             cfg_init,
    input  logic             cfg_done,
    input  logic             drained,
    input  logic             rise_now,
    output logic [1:0]       mode_q,
    output logic [DIV_W-1:0] div_q,
    output logic             clear,
    output logic             stream_en,
    output logic             free_clk,
    output logic             cfg_prog_n,
    output logic             busy,
    output logic             finished,
    output logic             timeout_err
);

    localparam int PW = $clog2(PROG_CYCLES + 1);
    localparam int TW = $clog2(TIMEOUT_CLKS + 1);

    seq_state_t    state_q;
    logic [PW-1:0] pcnt_q;
    logic [TW-1:0] tcnt_q;
    logic          can_start;

    assign can_start   = (state_q == ST_IDLE) || (state_q == ST_FINISH) ||
                         (state_q == ST_FAULT);
    assign clear       = can_start && start;
    assign stream_en   = (state_q == ST_STREAM);
    assign free_clk    = (state_q == ST_DRAIN);
    assign cfg_prog_n  = (state_q != ST_PROG);
    assign busy        = !can_start;
    assign finished    = (state_q == ST_FINISH);
    assign timeout_err = (state_q == ST_FAULT);

    // Sequencer state, pulse counter and drain timeout counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pcnt_q  <= '0;
            tcnt_q  <= '0;
            mode_q  <= '0;
            div_q   <= '0;
        end else begin
            case (state_q)
                ST_PROG: begin
                    pcnt_q <= pcnt_q + 1'b1;
                    if (pcnt_q == PW'(PROG_CYCLES - 1)) begin
                        state_q <= ST_WAIT_INIT;
                    end
                end
                ST_WAIT_INIT: begin
                    if (cfg_init) begin
                        state_q <= ST_STREAM;
                    end
                end
                ST_STREAM: begin
                    if (drained) begin
                        state_q <= ST_DRAIN;
                        tcnt_q  <= '0;
                    end
                end
                ST_DRAIN: begin
                    if (cfg_done) begin
                        state_q <= ST_FINISH;
                    end else if (tcnt_q == TW'(TIMEOUT_CLKS)) begin
                        state_q <= ST_FAULT;
                    end else if (rise_now) begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                default: begin
                    if (start) begin
                        state_q <= ST_PROG;
                        pcnt_q  <= '0;
                        mode_q  <= chain_mode;
                        div_q   <= div_half;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/cfg_streamer.sv
// Top of the concurrent serial configuration streamer.
// Joins the sequencer, the lane de-interleaver and the clock pacer.
// Assumes a single memory stream with bits interleaved per clock edge.
module cfg_streamer
    import cfg_streamer_pkg::*;
#(
    parameter int MAX_LANES    = 8,
    parameter int BYTE_W       = 8,
    parameter int DIV_W        = 8,
    parameter int PROG_CYCLES  = 8,
    parameter int TIMEOUT_CLKS = 64,
    parameter int SYS_MHZ      = 250,
    parameter int CHAIN_MBPS   = 66,
    parameter int TOTAL_MBPS   = 152
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           chain_mode,
    input  logic [DIV_W-1:0]     div_half,
    input  logic [BYTE_W-1:0]    mem_data,
    input  logic                 mem_valid,
    input  logic                 mem_last,
    output logic                 mem_ready,
    output logic                 cfg_prog_n,
    input  logic                 cfg_init,
    output logic                 cfg_cclk,
    output logic [MAX_LANES-1:0] cfg_data,
    input  logic                 cfg_done,
    output logic                 busy,
    output logic                 finished,
    output logic                 timeout_err
);

    logic [1:0]       mode_q;
    logic [DIV_W-1:0] div_q;
    logic             clear;
    logic             stream_en;
    logic             free_clk;
    logic             drained;
    logic             pend;
    logic             rise_now;
    logic             fall_now;

    cfg_seq_ctrl #(
        .DIV_W       (DIV_W),
        .PROG_CYCLES (PROG_CYCLES),
        .TIMEOUT_CLKS(TIMEOUT_CLKS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .chain_mode (chain_mode),
        .div_half   (div_half),
        .cfg_init   (cfg_init),
        .cfg_done   (cfg_done),
        .drained    (drained),
        .rise_now   (rise_now),
        .mode_q     (mode_q),
        .div_q      (div_q),
        .clear      (clear),
        .stream_en  (stream_en),
        .free_clk   (free_clk),
        .cfg_prog_n (cfg_prog_n),
        .busy       (busy),
        .finished   (finished),
        .timeout_err(timeout_err)
    );

    cfg_lane_unpack #(
        .MAX_LANES(MAX_LANES),
        .BYTE_W   (BYTE_W)
    ) u_unpack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .enable   (stream_en),
        .mode     (mode_q),
        .mem_data (mem_data),
        .mem_valid(mem_valid),
        .mem_last (mem_last),
        .mem_ready(mem_ready),
        .cclk     (cfg_cclk),
        .fall_now (fall_now),
        .pend     (pend),
        .drained  (drained),
        .cfg_data (cfg_data)
    );

    cfg_clk_pacer #(
        .DIV_W     (DIV_W),
        .SYS_MHZ   (SYS_MHZ),
        .CHAIN_MBPS(CHAIN_MBPS),
        .TOTAL_MBPS(TOTAL_MBPS)
    ) u_pacer (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_q),
        .div_half(div_q),
        .run     (stream_en || free_clk),
        .gate    (free_clk || pend),
        .cclk    (cfg_cclk),
        .rise_now(rise_now),
        .fall_now(fall_now)
    );

endmodule

// File: rtl/cfg_streamer_chk.sv
// Property checker for cfg_streamer, attached with bind below.
// Observes ports plus the latched lane mode; drives nothing.
module cfg_streamer_chk
    import cfg_streamer_pkg::*;
#(
    parameter int MAX_LANES    = 8,
    parameter int PROG_CYCLES  = 8,
    parameter int SYS_MHZ      = 250,
    parameter int CHAIN_MBPS   = 66,
    parameter int TOTAL_MBPS   = 152
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_prog_n,
    input logic                 cfg_init,
    input logic                 cfg_cclk,
    input logic [MAX_LANES-1:0] cfg_data,
    input logic                 cfg_done,
    input logic                 mem_ready,
    input logic                 busy,
    input logic                 finished,
    input logic                 timeout_err,
    input logic [1:0]           mode_q
);

    localparam int CW = 16;
    localparam logic [CW-1:0] FLOOR [4] = '{
        CW'(min_half(SYS_MHZ, CHAIN_MBPS, TOTAL_MBPS, 1)),
        CW'(min_half(SYS_MHZ, CHAIN_MBPS, TOTAL_MBPS, 2)),
        CW'(min_half(SYS_MHZ, CHAIN_MBPS, TOTAL_MBPS, 4)),
        CW'(min_half(SYS_MHZ, CHAIN_MBPS, TOTAL_MBPS, 8))
    };

    logic [CW-1:0]        low_cnt;
    logic [CW-1:0]        high_cnt;
    logic                 armed;
    logic [MAX_LANES-1:0] live_mask;

    assign live_mask = ~({MAX_LANES{1'b1}} << (4'd1 << mode_q));

    // Count program-low cycles and clock-high cycles (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            high_cnt <= '0;
            armed    <= 1'b0;
        end else begin
            low_cnt  <= !cfg_prog_n ? ((low_cnt == '1) ? low_cnt : low_cnt + 1'b1) : '0;
            high_cnt <= cfg_cclk ? ((high_cnt == '1) ? high_cnt : high_cnt + 1'b1) : '0;
            if (!cfg_prog_n) armed <= 1'b0;
            else if (cfg_init) armed <= 1'b1;
        end
    end

    // R1: program pulse width
    p_prog_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_prog_n) |-> (low_cnt == CW'(PROG_CYCLES)));

    // R2: no clock before init
    p_clk_after_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_cclk) |-> armed);

    // R3: data holds across high phase
    p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_cclk |-> $stable(cfg_data));

    // R3: unused lanes zero
    p_idle_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_data & ~live_mask) == '0);

    // R5: high phase never shorter than the rate floor
    p_high_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_cclk) |-> (high_cnt >= FLOOR[mode_q]));

    // R7: finish only caused by done
    p_finish_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(finished) |-> $past(cfg_done));

    // R8: timeout only while done low
    p_timeout_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> !$past(cfg_done));

    // R10: ready confined to streaming
    p_ready_streaming_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ready |-> (busy && cfg_prog_n));

endmodule

bind cfg_streamer cfg_streamer_chk #(
    .MAX_LANES  (MAX_LANES),
    .PROG_CYCLES(PROG_CYCLES),
    .SYS_MHZ    (SYS_MHZ),
    .CHAIN_MBPS (CHAIN_MBPS),
    .TOTAL_MBPS (TOTAL_MBPS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_prog_n (cfg_prog_n),
    .cfg_init   (cfg_init),
    .cfg_cclk   (cfg_cclk),
    .cfg_data   (cfg_data),
    .cfg_done   (cfg_done),
    .mem_ready  (mem_ready),
    .busy       (busy),
    .finished   (finished),
    .timeout_err(timeout_err),
    .mode_q     (mode_q)
);

// File: tb/cfg_streamer_bench.sv
// Sweep bench: every lane count against several dividers, with and
// without memory gaps, plus timeout runs. Expected values are computed
// arithmetically from the requirements.
module cfg_streamer_bench;

    localparam int PROG  = 8;
    localparam int TMO   = 64;
    localparam int NBYTE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] chain_mode = 2'd0;
    logic [7:0] div_half = 8'd0;
    logic [7:0] mem_data = 8'd0;
    logic       mem_valid = 1'b0;
    logic       mem_last = 1'b0;
    logic       mem_ready;
    logic       cfg_prog_n;
    logic       cfg_init = 1'b0;
    logic       cfg_cclk;
    logic [7:0] cfg_data;
    logic       cfg_done = 1'b0;
    logic       busy;
    logic       finished;
    logic       timeout_err;

    int vectors = 0;
    int errors  = 0;
    int total_cyc = 0;

    always #2 clk = ~clk;

    cfg_streamer #(.PROG_CYCLES(PROG), .TIMEOUT_CLKS(TMO)) u_cfg_streamer (
        .clk(clk), .rst_n(rst_n), .start(start), .chain_mode(chain_mode),
        .div_half(div_half), .mem_data(mem_data), .mem_valid(mem_valid),
        .mem_last(mem_last), .mem_ready(mem_ready), .cfg_prog_n(cfg_prog_n),
        .cfg_init(cfg_init), .cfg_cclk(cfg_cclk), .cfg_data(cfg_data),
        .cfg_done(cfg_done), .busy(busy), .finished(finished),
        .timeout_err(timeout_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bytev(input int i, input int seed);
        return 8'((i * 53 + seed * 29 + 7) ^ (i << 3));
    endfunction

    // Half period from the two rate limits (250 MHz, 66 and 152 Mb/s).
    function automatic int exp_half(input int mode, input int div);
        int n, per, agg, p, h;
        n   = 1 << mode;
        per = (250 + 65) / 66;
        agg = (250 * n + 151) / 152;
        p   = (per > agg) ? per : agg;
        h   = (p + 1) / 2;
        if (h < 2) h = 2;
        return (div > h) ? div : h;
    endfunction

    task automatic run(input int mode, input int div, input bit stall,
                       input int done_after, input int seed);
        logic [7:0] rx [0:127];
        int n, bits, h, idx, cyc, nrise, prog_low, rise_bad, bad_ready;
        int phase, hmin, hmax, lmin, lmax, idly, tail, data_bad;
        bit drv_valid, seen_ready, went_busy, seen_fall, prev, hung;
        n = 1 << mode; bits = 8 * NBYTE / n; h = exp_half(mode, div);
        idx = 0; cyc = 0; nrise = 0; prog_low = 0; rise_bad = 0; bad_ready = 0;
        phase = 0; hmin = 1 << 20; hmax = 0; lmin = 1 << 20; lmax = 0; idly = 0;
        tail = -1; data_bad = 0; drv_valid = 0; seen_ready = 0; went_busy = 0;
        seen_fall = 0; prev = cfg_cclk; hung = 0;
        chain_mode = 2'(mode); div_half = 8'(div);
        for (int i = 0; i < 128; i++) rx[i] = 8'd0;
        forever begin
            @(negedge clk);
            cyc++; total_cyc++;
            start = (cyc == 1);
            if (drv_valid && seen_ready) idx++;
            seen_ready = mem_ready;
            if (mem_ready && !busy) bad_ready++;
            if (busy) went_busy = 1;
            if (!cfg_prog_n) prog_low++;
            phase++;
            if (cfg_cclk && !prev) begin
                if (!cfg_init) rise_bad++;
                if (nrise < 128) rx[nrise] = cfg_data;
                nrise++;
                if (seen_fall) begin
                    if (phase - 1 < lmin) lmin = phase - 1;
                    if (phase - 1 > lmax) lmax = phase - 1;
                end
                phase = 1;
            end else if (!cfg_cclk && prev) begin
                if (phase - 1 < hmin) hmin = phase - 1;
                if (phase - 1 > hmax) hmax = phase - 1;
                seen_fall = 1;
                phase = 1;
            end
            prev = cfg_cclk;
            if (!cfg_prog_n) begin cfg_init = 0; idly = 0; end
            else if (idly < 5) idly++;
            else cfg_init = 1;
            if (!cfg_prog_n) cfg_done = 0;
            else if (done_after >= 0 && nrise >= bits + done_after) cfg_done = 1;
            drv_valid = (idx < NBYTE) && (!stall || (cyc % 5) < 2);
            mem_valid = drv_valid;
            mem_data  = bytev(idx, seed);
            mem_last  = (idx == NBYTE - 1);
            if (went_busy && !busy && tail < 0) tail = 40;
            if (tail > 0) tail--;
            if (tail == 0) break;
            if (cyc > 20000 || total_cyc > 190000) begin hung = 1; break; end
        end
        check(!hung, "watchdog", cyc, 0);
        for (int r = 0; r < bits; r++) begin
            for (int k = 0; k < 8; k++) begin
                int b;
                logic e;
                b = r * n + k;
                e = (k < n) ? bytev(b / 8, seed)[b % 8] : 1'b0;
                if (rx[r][k] !== e) data_bad++;
            end
        end
        check(prog_low == PROG, "R1 program pulse width", prog_low, PROG);
        check(rise_bad == 0, "R2 rises with init low", rise_bad, 0);
        check(data_bad == 0, "R3 lane bit mismatches", data_bad, 0);
        check(nrise == bits + ((done_after >= 0) ? done_after : TMO),
              "R4 rising edge count", nrise, bits + ((done_after >= 0) ? done_after : TMO));
        check(hmin >= h, "R5 min high phase", hmin, h);
        check(lmin >= h, "R5 min low phase", lmin, h);
        if (!stall) begin
            check(hmax == h, "R6 high phase width", hmax, h);
            check(lmax == h, "R6 low phase width", lmax, h);
        end
        if (done_after >= 0) begin
            check(finished && !timeout_err && !busy, "R7 finished flags",
                  {finished, timeout_err, busy}, 3'b100);
        end else begin
            check(timeout_err && !finished && !busy, "R8 timeout flags",
                  {finished, timeout_err, busy}, 3'b010);
        end
        check(cfg_cclk == 0, "R7 clock parked low", cfg_cclk, 0);
        check(bad_ready == 0, "R10 ready while idle", bad_ready, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check({cfg_prog_n, cfg_cclk, cfg_data, mem_ready, busy, finished, timeout_err} == 14'b10_0000_0000_0000,
              "R9 reset outputs",
              {cfg_prog_n, cfg_cclk, cfg_data, mem_ready, busy, finished, timeout_err},
              14'b10_0000_0000_0000);
        rst_n = 1'b1;
        @(negedge clk);
        check({cfg_prog_n, cfg_cclk, cfg_data, mem_ready, busy, finished, timeout_err} == 14'b10_0000_0000_0000,
              "R9 post-reset outputs",
              {cfg_prog_n, cfg_cclk, cfg_data, mem_ready, busy, finished, timeout_err},
              14'b10_0000_0000_0000);
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 3; d++) begin
                for (int s = 0; s < 2; s++) begin
                    run(m, (d == 0) ? 0 : ((d == 1) ? 3 : 9), s[0],
                        (d == 1) ? 0 : 3, m * 7 + d * 3 + s);
                end
            end
        end
        run(0, 0, 1'b0, -1, 41);
        run(3, 5, 1'b1, -1, 42);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule